// File: doc/BRIEF.md
# Dot-Rate Video Serializer with Load Strobe Narrowing

This block turns character or pattern bytes from a slow controller into a serial pixel stream at dot rate. A free-running oscillator clock is divided to make the dot clock. An 8-bit parallel-in, serial-out register sends pixels out of its top bit, one per dot.

The controller cannot make a strobe narrower than two dot periods. It presents a byte together with a load request that is two dots wide. The block samples the request on the falling half of each dot and keeps a one-dot-delayed copy of that sample. It combines the two into an active-low load enable that lasts exactly one dot period. The enable changes only on falling dot edges, so it is settled when the register takes it at the next rising edge.

When the controller writes a byte every eight dots it gets a continuous pixel stream. Writing a zero byte after the last character keeps the output black for the rest of the line. Blanking and sync are produced elsewhere.

Top module: `video_shift_stage`

## Requirements
- R1: `dotClk` is the oscillator divided by `DOT_DIV` (default 2). After reset is released, the first oscillator edge is a rising dot edge, and with the default `dotClk` toggles on every oscillator edge.
- R2: While `rstN` is low, `dotClk` is 0, `loadN` is 1 and `videoOut` is 0, and the pixel register is cleared.
- R3: `loadReq` is sampled only on falling dot edges, so `loadN` never changes at a rising dot edge.
- R4: A 0-to-1 change of the sampled request drives `loadN` low for exactly one dot period, starting at the first falling dot edge after the request rises.
- R5: At a rising dot edge with `loadN` low, the register takes `pixByte`, and `videoOut` shows `pixByte[7]` right after that edge.
- R6: At any other rising dot edge the register moves one place toward bit 7 and takes 0 into bit 0. A loaded byte therefore appears as eight pixels, bit 7 first, followed by black. `videoOut` never changes at a falling dot edge.
- R7: A request held high longer than two dots loads only once. A new load needs the request to be seen low at one or more falling dot edges first.
- R8: Bytes requested every eight dots come out as an unbroken stream, with no bit dropped or repeated, and a zero byte gives black pixels.
- R9: A request only one dot wide still produces exactly one load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Oscillator clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadReq | input | 1 | Load request from the controller, active high, normally two dots wide |
| pixByte | input | 8 | Byte to be serialized, held while the request is active |
| dotClk | output | 1 | Divided dot clock |
| loadN | output | 1 | Narrowed active-low load enable, one dot wide |
| videoOut | output | 1 | Serial pixel output, top bit of the pixel register |

## Verification
The stream is driven with a sequence of bytes at eight-dot spacing: alternating bits, all ones, a lone low bit, a lone high bit, a centred block and a zero byte. Each dot is compared with the expected bit, and the ones in every eight-dot window are counted, so a shifted, dropped or repeated bit shows up as a mismatch at a known dot. Directed runs then apply a request held for five dots, a request that drops for exactly one dot before rising again, and a one-dot request. These three separate edge detection from level detection and show the re-arm condition. A reset in the middle of a byte checks that the register clears, and the dots after each byte check that zeros fill in.

// File: rtl/vshift_pkg.sv
`timescale 1ns/1ps
package vshift_pkg;
  // Strobes passed from the timing control to the pixel datapath
  typedef struct packed {
    logic riseTick;  // this oscillator edge is a rising dot edge
    logic fallTick;  // this oscillator edge is a falling dot edge
    logic loadN;     // narrowed active-low load enable
  } dotStrobe_t;
endpackage

// File: rtl/vshift_ctrl.sv
`timescale 1ns/1ps
module vshift_ctrl
  import vshift_pkg::*;
#(
  parameter int DOT_DIV = 2
) (
  input  logic       oscClk,
  input  logic       rstN,
  input  logic       loadReq,
  output dotStrobe_t strb,
  output logic       dotClk
);
  localparam int CNT_W = (DOT_DIV > 2) ? $clog2(DOT_DIV) : 1;
  localparam int HALF  = DOT_DIV / 2;

  logic [CNT_W-1:0] phaseCnt;
  logic riseTick, fallTick;
  logic reqSeen, reqPrev;
  logic loadNarrowN;

  assign riseTick = (phaseCnt == '0);
  assign fallTick = (phaseCnt == CNT_W'(HALF));

  // oscillator divider
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (phaseCnt == CNT_W'(DOT_DIV - 1)) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      dotClk <= 1'b0;
    end else if (riseTick) begin
      dotClk <= 1'b1;
    end else if (fallTick) begin
      dotClk <= 1'b0;
    end
  end

  // request sampled on the falling dot half, plus a copy one dot older
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      reqSeen <= 1'b0;
      reqPrev <= 1'b0;
    end else if (fallTick) begin
      reqSeen <= loadReq;
      reqPrev <= reqSeen;
    end
  end

  // low for one dot after a fresh rise of the sampled request
  assign loadNarrowN = ~(reqSeen & ~reqPrev);

  assign strb.riseTick = riseTick;
  assign strb.fallTick = fallTick;
  assign strb.loadN    = loadNarrowN;

  assert_dot_rise_R1: assert property (@(posedge oscClk) disable iff (!rstN)
    riseTick |=> dotClk);
  assert_dot_fall_R1: assert property (@(posedge oscClk) disable iff (!rstN)
    fallTick |=> !dotClk);
  assert_load_settled_R3: assert property (@(posedge oscClk) disable iff (!rstN)
    riseTick |=> $stable(loadNarrowN));
  assert_one_dot_load_R4: assert property (@(posedge oscClk) disable iff (!rstN)
    (fallTick && !loadNarrowN) |=> loadNarrowN);
endmodule

// File: rtl/vshift_dp.sv
`timescale 1ns/1ps
module vshift_dp
  import vshift_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              oscClk,
  input  logic              rstN,
  input  dotStrobe_t        strb,
  input  logic [BYTE_W-1:0] pixByte,
  output logic              videoOut
);
  localparam int  MSB      = BYTE_W - 1;
  localparam logic FILL_BIT = 1'b0;

  logic [BYTE_W-1:0] shiftReg;

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.riseTick) begin
      if (!strb.loadN) begin
        shiftReg <= pixByte;
      end else begin
        shiftReg <= {shiftReg[MSB-1:0], FILL_BIT};
      end
    end
  end

  assign videoOut = shiftReg[MSB];

  assert_load_msb_R5: assert property (@(posedge oscClk) disable iff (!rstN)
    (strb.riseTick && !strb.loadN) |=> (videoOut == $past(pixByte[MSB])));
  assert_quiet_fall_R6: assert property (@(posedge oscClk) disable iff (!rstN)
    strb.fallTick |=> $stable(videoOut));
  assert_black_stays_R6: assert property (@(posedge oscClk) disable iff (!rstN)
    (strb.riseTick && strb.loadN && shiftReg == '0) |=> (shiftReg == '0));
endmodule

// File: rtl/video_shift_stage.sv
`timescale 1ns/1ps
module video_shift_stage
  import vshift_pkg::*;
#(
  parameter int DOT_DIV = 2,
  parameter int BYTE_W  = 8
) (
  input  logic              oscClk,
  input  logic              rstN,
  input  logic              loadReq,
  input  logic [BYTE_W-1:0] pixByte,
  output logic              dotClk,
  output logic              loadN,
  output logic              videoOut
);
  dotStrobe_t strb;

  vshift_ctrl #(.DOT_DIV(DOT_DIV)) uCtrl (
    .oscClk (oscClk),
    .rstN   (rstN),
    .loadReq(loadReq),
    .strb   (strb),
    .dotClk (dotClk)
  );

  vshift_dp #(.BYTE_W(BYTE_W)) uDp (
    .oscClk  (oscClk),
    .rstN    (rstN),
    .strb    (strb),
    .pixByte (pixByte),
    .videoOut(videoOut)
  );

  assign loadN = strb.loadN;
endmodule

// File: tb/tb_video_shift_stage.sv
`timescale 1ns/1ps
module tb_video_shift_stage;
  logic       oscClk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadReq = 1'b0;
  logic [7:0] pixByte = 8'h00;
  logic       dotClk, loadN, videoOut;

  int checks = 0;
  int fails = 0;
  logic vidS, ldnS, dHi, dLo;

  localparam int NVEC = 6;
  localparam logic [7:0] BYTES [NVEC] = '{8'hA5, 8'hFF, 8'h01, 8'h80, 8'h3C, 8'h00};
  localparam int ONES [NVEC] = '{4, 8, 1, 1, 4, 0};

  video_shift_stage dut (
    .oscClk(oscClk), .rstN(rstN), .loadReq(loadReq), .pixByte(pixByte),
    .dotClk(dotClk), .loadN(loadN), .videoOut(videoOut)
  );

  always #2.5 oscClk = ~oscClk;

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic chkInt(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // one dot: rising edge, sample pixel, drive inputs, falling edge, sample load
  task automatic step(input logic r, input logic [7:0] b);
    @(posedge oscClk);
    @(negedge oscClk);
    vidS = videoOut;
    dHi = dotClk;
    loadReq = r;
    pixByte = b;
    @(posedge oscClk);
    @(negedge oscClk);
    ldnS = loadN;
    dLo = dotClk;
  endtask

  task automatic doReset();
    @(negedge oscClk);
    rstN = 1'b0;
    loadReq = 1'b0;
    pixByte = 8'h00;
    #1;
    chk("R2 video in reset", videoOut, 1'b0);
    chk("R2 loadN in reset", loadN, 1'b1);
    chk("R2 dotClk in reset", dotClk, 1'b0);
    repeat (2) @(negedge oscClk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge oscClk);
    fails++;
    $display("FAIL watchdog expired, all requirements got=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    int acc;
    logic expV;
    repeat (3) @(negedge oscClk);
    doReset();

    // table walk: one byte every eight dots, two-dot request at the start
    acc = 0;
    for (int i = 0; i < NVEC; i++) begin
      for (int j = 0; j < 8; j++) begin
        step(j < 2, BYTES[i]);
        if (j == 0) expV = (i == 0) ? 1'b0 : BYTES[i-1][0];
        else expV = BYTES[i][8-j];
        chk($sformatf("R8 stream byte %0d dot %0d", i, j), vidS, expV);
        chk($sformatf("R4 load width byte %0d dot %0d", i, j), ldnS, (j != 0));
        if (i == 0 && j < 2) begin
          chk("R1 dotClk high after rise", dHi, 1'b1);
          chk("R1 dotClk low after fall", dLo, 1'b0);
        end
        if (j == 0 && i > 0) begin
          acc += int'(vidS);
          chkInt($sformatf("R8 ones in byte %0d", i - 1), acc, ONES[i-1]);
          acc = 0;
        end else if (j > 0) begin
          acc += int'(vidS);
        end
      end
    end
    step(1'b0, 8'h00);
    chk("R8 last bit of final byte", vidS, BYTES[NVEC-1][0]);
    acc += int'(vidS);
    chkInt("R8 ones in final zero byte", acc, ONES[NVEC-1]);

    // R7: request held five dots loads once, then zeros fill (R6)
    doReset();
    for (int k = 0; k < 12; k++) begin
      step(k < 5, 8'hC3);
      chk($sformatf("R7 long request loadN dot %0d", k), ldnS, (k != 0));
      if (k == 0 || k > 8) expV = 1'b0;
      else expV = 8'hC3 >> (8 - k);
      chk($sformatf("R6 pixels after long request dot %0d", k), vidS, expV);
    end

    // R7: one low dot re-arms the narrowing
    doReset();
    for (int k = 0; k < 13; k++) begin
      step((k != 2) && (k < 5), (k < 3) ? 8'hFF : 8'h55);
      chk($sformatf("R7 re-arm loadN dot %0d", k), ldnS, !(k == 0 || k == 3));
      if (k == 0 || k == 12) expV = 1'b0;
      else if (k < 4) expV = 1'b1;
      else expV = 8'h55 >> (11 - k);
      chk($sformatf("R5 re-arm pixels dot %0d", k), vidS, expV);
    end

    // R9: one-dot request
    doReset();
    for (int k = 0; k < 10; k++) begin
      step(k == 0, 8'h81);
      chk($sformatf("R9 short request loadN dot %0d", k), ldnS, (k != 0));
      if (k == 0 || k == 9) expV = 1'b0;
      else expV = 8'h81 >> (8 - k);
      chk($sformatf("R9 short request pixels dot %0d", k), vidS, expV);
    end

    // R2: reset in the middle of a byte of ones
    doReset();
    step(1'b1, 8'hFF);
    step(1'b1, 8'hFF);
    step(1'b0, 8'hFF);
    chk("R5 ones loaded before reset", vidS, 1'b1);
    doReset();
    step(1'b0, 8'h00);
    chk("R2 register cleared by reset", vidS, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule